// File: doc/BRIEF.md
# Carry-Accumulating Bit Manipulation Unit

This unit performs one bit-level operation per clock on a byte operand. A one-bit carry flag serves as a Boolean accumulator. A caller presents the operand, a bit number, an operation code and the current carry and zero flags, all qualified by `inValid`. One clock later the unit returns four results:

- the possibly modified byte,
- a write-enable telling the caller whether that byte must be written back,
- the next carry flag,
- the next zero flag.

The operations fall into three groups:

- **Bit modification:** force the selected bit to one, force it to zero, or toggle it.
- **Test:** report the selected bit through the zero flag.
- **Carry accumulation:** copy the carry (or its complement) into the selected bit, load the bit (or its complement) into carry, and combine carry with the bit by AND, OR or XOR. Each of the three logic forms has a variant that uses the complemented bit.

Operand fetch, address calculation and instruction decoding happen outside the unit. The bit number may come from an immediate field or from a register, and only its low three bits matter.

Top module: `bitu_top`

## Requirements
- R1: The low three bits of `bitNum` select bit 0 (LSB) to bit 7 of `operand`; all higher bits of `bitNum` are ignored.
- R2: Code 0 forces the selected bit to 1, code 1 forces it to 0, code 2 toggles it. Each of these raises `byteWrite`, and all other bits of `resultByte` equal `operand`.
- R3: Code 6 writes `carryIn` into the selected bit and code 7 writes its complement. Both raise `byteWrite` and leave carry unchanged.
- R4: Code 4 loads the selected bit into carry and code 5 loads its complement. Neither writes the byte.
- R5: Code 8 sets carry to carry AND bit, and code 9 sets it to carry AND NOT bit.
- R6: Code 10 sets carry to carry OR bit, and code 11 sets it to carry OR NOT bit.
- R7: Code 12 sets carry to carry XOR bit, and code 13 sets it to carry XOR NOT bit.
- R8: Code 3 (test) sets `zeroOut` to the complement of the selected bit. It returns `operand` unchanged, with `byteWrite` low and carry unchanged. Codes 4, 5 and 8 to 13 also never write the byte.
- R9: The zero flag passes through unchanged for every code except 3. Carry passes through unchanged for codes 0, 1, 2 and 3.
- R10: Codes 14 and 15 change nothing: the byte is returned as given, both flags pass through, and `byteWrite` stays low.
- R11: The results and `outValid` appear one clock after the edge that samples `inValid` high. After an edge with `inValid` low, `outValid` is low and the other outputs hold their values.
- R12: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Qualifies the operation inputs |
| opCode | input | 4 | Operation code |
| bitNum | input | 8 | Bit number; only the low 3 bits are used |
| operand | input | 8 | Byte operand |
| carryIn | input | 1 | Current carry flag |
| zeroIn | input | 1 | Current zero flag |
| outValid | output | 1 | Results are fresh this cycle |
| resultByte | output | 8 | Byte after the operation |
| byteWrite | output | 1 | Byte must be written back |
| carryOut | output | 1 | Next carry flag |
| zeroOut | output | 1 | Next zero flag |

## Verification
Every result (byte, write-enable, both flags and `outValid`) is due exactly one rising edge after the edge that samples the request. There is a single register stage and no other latency.

The bench drives each request just after a falling edge and reads the outputs at the following falling edge. Requests can therefore stream back to back, and each sample falls midway between the registering edge and the next one.

The hold case, where outputs stay put after an idle cycle, is sampled at the same one-cycle point after a cycle with `inValid` low.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

  typedef enum logic [3:0] {
    OP_SET    = 4'd0,
    OP_CLR    = 4'd1,
    OP_FLIP   = 4'd2,
    OP_TEST   = 4'd3,
    OP_LOAD   = 4'd4,
    OP_LOADN  = 4'd5,
    OP_STORE  = 4'd6,
    OP_STOREN = 4'd7,
    OP_AND    = 4'd8,
    OP_ANDN   = 4'd9,
    OP_OR     = 4'd10,
    OP_ORN    = 4'd11,
    OP_XOR    = 4'd12,
    OP_XORN   = 4'd13,
    OP_RSV0   = 4'd14,
    OP_RSV1   = 4'd15
  } bitOp_e;

  // Value written into the selected bit.
  typedef enum logic [1:0] {
    BIT_ONE   = 2'd0,
    BIT_ZERO  = 2'd1,
    BIT_FLIP  = 2'd2,
    BIT_CARRY = 2'd3
  } bitSrc_e;

  // How the next carry is formed.
  typedef enum logic [1:0] {
    CF_LOAD = 2'd0,
    CF_AND  = 2'd1,
    CF_OR   = 2'd2,
    CF_XOR  = 2'd3
  } carryFn_e;

  typedef struct packed {
    logic     writeByte;
    bitSrc_e  bitSrc;
    logic     invStore;
    logic     carryUpd;
    carryFn_e carryFn;
    logic     invBit;
    logic     zeroUpd;
  } ctrlStrobe_t;

endpackage

// File: rtl/bitu_ctrl.sv
module bitu_ctrl
  import bitu_pkg::*;
(
  input  logic [3:0]  opCode,
  output ctrlStrobe_t strobe
);

  bitOp_e op;
  assign op = bitOp_e'(opCode);

  always_comb begin
    strobe = '{writeByte: 1'b0, bitSrc: BIT_ONE, invStore: 1'b0,
               carryUpd: 1'b0, carryFn: CF_LOAD, invBit: 1'b0,
               zeroUpd: 1'b0};
    case (op)
      OP_SET: begin
        strobe.writeByte = 1'b1;
        strobe.bitSrc    = BIT_ONE;
      end
      OP_CLR: begin
        strobe.writeByte = 1'b1;
        strobe.bitSrc    = BIT_ZERO;
      end
      OP_FLIP: begin
        strobe.writeByte = 1'b1;
        strobe.bitSrc    = BIT_FLIP;
      end
      OP_TEST: begin
        strobe.zeroUpd = 1'b1;
      end
      OP_STORE, OP_STOREN: begin
        strobe.writeByte = 1'b1;
        strobe.bitSrc    = BIT_CARRY;
        strobe.invStore  = (op == OP_STOREN);
      end
      OP_LOAD, OP_LOADN: begin
        strobe.carryUpd = 1'b1;
        strobe.carryFn  = CF_LOAD;
        strobe.invBit   = (op == OP_LOADN);
      end
      OP_AND, OP_ANDN: begin
        strobe.carryUpd = 1'b1;
        strobe.carryFn  = CF_AND;
        strobe.invBit   = (op == OP_ANDN);
      end
      OP_OR, OP_ORN: begin
        strobe.carryUpd = 1'b1;
        strobe.carryFn  = CF_OR;
        strobe.invBit   = (op == OP_ORN);
      end
      OP_XOR, OP_XORN: begin
        strobe.carryUpd = 1'b1;
        strobe.carryFn  = CF_XOR;
        strobe.invBit   = (op == OP_XORN);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bitu_datapath.sv
module bitu_datapath
  import bitu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctrlStrobe_t       strobe,
  input  logic [NUM_W-1:0]  bitNum,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              zeroIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resultByte,
  output logic              byteWrite,
  output logic              carryOut,
  output logic              zeroOut
);

  localparam int SEL_W = $clog2(DATA_W);

  logic [SEL_W-1:0]  idx;
  logic              selBit;
  logic              effBit;
  logic              newBit;
  logic              nextCarry;
  logic              nextZero;
  logic [DATA_W-1:0] nextByte;

  assign idx    = bitNum[SEL_W-1:0];
  assign selBit = operand[idx];
  assign effBit = selBit ^ strobe.invBit;

  always_comb begin
    case (strobe.bitSrc)
      BIT_ONE:  newBit = 1'b1;
      BIT_ZERO: newBit = 1'b0;
      BIT_FLIP: newBit = ~selBit;
      default:  newBit = carryIn ^ strobe.invStore;
    endcase
  end

  always_comb begin
    nextCarry = carryIn;
    if (strobe.carryUpd) begin
      case (strobe.carryFn)
        CF_LOAD: nextCarry = effBit;
        CF_AND:  nextCarry = carryIn & effBit;
        CF_OR:   nextCarry = carryIn | effBit;
        default: nextCarry = carryIn ^ effBit;
      endcase
    end
  end

  assign nextZero = strobe.zeroUpd ? ~selBit : zeroIn;

  for (genvar g = 0; g < DATA_W; g++) begin : gBitLane
    assign nextByte[g] = (strobe.writeByte && (idx == SEL_W'(g))) ? newBit
                                                                  : operand[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      resultByte <= '0;
      byteWrite  <= 1'b0;
      carryOut   <= 1'b0;
      zeroOut    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        resultByte <= nextByte;
        byteWrite  <= strobe.writeByte;
        carryOut   <= nextCarry;
        zeroOut    <= nextZero;
      end
    end
  end

  // R11: a sampled request yields fresh results on the next cycle
  assert_valid_next_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R11: idle cycles hold the outputs
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(resultByte) && $stable(carryOut)
                  && $stable(zeroOut) && $stable(byteWrite)));

  // R2: only the selected bit may differ from the operand
  assert_unsel_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (((resultByte ^ $past(operand))
                  & ~(DATA_W'(1) << $past(idx))) == '0));

  // R8: without a write strobe the byte is returned intact
  assert_no_write_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strobe.writeByte) |=>
      (!byteWrite && resultByte == $past(operand)));

  // R9: zero passes through unless the test strobe is up
  assert_zero_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strobe.zeroUpd) |=> (zeroOut == $past(zeroIn)));

  // R9: carry passes through unless a carry strobe is up
  assert_carry_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strobe.carryUpd) |=> (carryOut == $past(carryIn)));

endmodule

// File: rtl/bitu_top.sv
module bitu_top
  import bitu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [NUM_W-1:0]  bitNum,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              zeroIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resultByte,
  output logic              byteWrite,
  output logic              carryOut,
  output logic              zeroOut
);

  ctrlStrobe_t strobe;

  bitu_ctrl uCtrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  bitu_datapath #(
    .DATA_W (DATA_W),
    .NUM_W  (NUM_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .strobe     (strobe),
    .bitNum     (bitNum),
    .operand    (operand),
    .carryIn    (carryIn),
    .zeroIn     (zeroIn),
    .outValid   (outValid),
    .resultByte (resultByte),
    .byteWrite  (byteWrite),
    .carryOut   (carryOut),
    .zeroOut    (zeroOut)
  );

endmodule

// File: tb/bitu_top_test.sv
`timescale 1ns/1ps
module bitu_top_test;

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] num;
    logic [7:0] data;
    logic       c;
    logic       z;
    logic [7:0] expByte;
    logic       expC;
    logic       expZ;
    logic       expWe;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  8'h03, 8'h00, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0, 1'b1}, // R2 set
    '{4'd1,  8'hFF, 8'hFF, 1'b1, 1'b1, 8'h7F, 1'b1, 1'b1, 1'b1}, // R2 clear, R1 high bits
    '{4'd2,  8'h00, 8'hA5, 1'b0, 1'b1, 8'hA4, 1'b0, 1'b1, 1'b1}, // R2 toggle
    '{4'd3,  8'h02, 8'h04, 1'b1, 1'b1, 8'h04, 1'b1, 1'b0, 1'b0}, // R8 test one
    '{4'd3,  8'h03, 8'h04, 1'b0, 1'b0, 8'h04, 1'b0, 1'b1, 1'b0}, // R8 test zero
    '{4'd4,  8'h07, 8'h80, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0}, // R4 load
    '{4'd5,  8'h07, 8'h80, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0}, // R4 load inverted
    '{4'd6,  8'h05, 8'h00, 1'b1, 1'b0, 8'h20, 1'b1, 1'b0, 1'b1}, // R3 store
    '{4'd7,  8'h05, 8'hFF, 1'b1, 1'b1, 8'hDF, 1'b1, 1'b1, 1'b1}, // R3 store inverted
    '{4'd8,  8'h01, 8'h02, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0}, // R5 and
    '{4'd9,  8'h01, 8'h02, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0}, // R5 and inverted
    '{4'd10, 8'h06, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0}, // R6 or
    '{4'd11, 8'h06, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0}, // R6 or inverted
    '{4'd12, 8'h04, 8'h10, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0}, // R7 xor
    '{4'd13, 8'h04, 8'h10, 1'b1, 1'b0, 8'h10, 1'b1, 1'b0, 1'b0}, // R7 xor inverted
    '{4'd14, 8'h02, 8'h5A, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b0}, // R10 code 14
    '{4'd15, 8'h00, 8'hC3, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b0}, // R10 code 15
    '{4'd0,  8'hF8, 8'h00, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0, 1'b1}  // R1 upper bits ignored, R9
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] bitNum = '0;
  logic [7:0] operand = '0;
  logic       carryIn = 1'b0;
  logic       zeroIn = 1'b0;
  logic       outValid;
  logic [7:0] resultByte;
  logic       byteWrite;
  logic       carryOut;
  logic       zeroOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bitu_top uut (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .opCode     (opCode),
    .bitNum     (bitNum),
    .operand    (operand),
    .carryIn    (carryIn),
    .zeroIn     (zeroIn),
    .outValid   (outValid),
    .resultByte (resultByte),
    .byteWrite  (byteWrite),
    .carryOut   (carryOut),
    .zeroOut    (zeroOut)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {v,byte,we,c,z}=%h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pack_out();
    return {outValid, resultByte, byteWrite, carryOut, zeroOut};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", pack_out(), 12'h000);
    rstN = 1'b1;
    @(negedge clk);
    // R11: results stream back to back, one cycle after each request
    for (int i = 0; i < NV; i++) begin
      inValid = 1'b1;
      opCode  = VEC[i].op;
      bitNum  = VEC[i].num;
      operand = VEC[i].data;
      carryIn = VEC[i].c;
      zeroIn  = VEC[i].z;
      @(negedge clk);
      check($sformatf("R1-vector %0d (R2..R10,R11)", i), pack_out(),
            {1'b1, VEC[i].expByte, VEC[i].expWe, VEC[i].expC, VEC[i].expZ});
    end
    // R11: idle cycle keeps outputs, outValid low
    inValid = 1'b0;
    opCode  = 4'd2;
    operand = 8'h3C;
    carryIn = 1'b0;
    zeroIn  = 1'b1;
    @(negedge clk);
    check("R11 idle hold", pack_out(), {1'b0, 8'h01, 1'b1, 1'b1, 1'b0});
    // R9: toggle keeps both flags as given (carry 1, zero 1)
    inValid = 1'b1;
    opCode  = 4'd2;
    bitNum  = 8'h07;
    operand = 8'h80;
    carryIn = 1'b1;
    zeroIn  = 1'b1;
    @(negedge clk);
    check("R9 toggle flags pass", pack_out(), {1'b1, 8'h00, 1'b1, 1'b1, 1'b1});
    // R12: reset in mid-stream clears everything
    rstN = 1'b0;
    @(negedge clk);
    check("R12 reset again", pack_out(), 12'h000);
    inValid = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule